// File: doc/BRIEF.md
# Integer Execute Stage with Register File

This block is the execute step of a small 32-bit load/store core. Each clock cycle it may accept one instruction word, qualified by a valid strobe. It decodes the word and reads up to two operands from a 32-entry register file. It then forms a result and commits that result to the register file on the next rising clock edge. Three operations are supported: a register-register add, an add of a sign-extended 16-bit constant, and a logical left shift by a 5-bit amount held in the instruction.

The write-back outputs (`wb_en`, `wb_addr`, `wb_data`) are combinational. They describe the write that the current instruction will commit at the coming edge. `illegal` flags an unsupported word during the cycle it is presented. A separate debug address selects any register, and the debug data port shows its contents combinationally.

Top module: `rfx_exec_top`

## Requirements
- R1: The register file holds 32 registers of 32 bits, each selected by a 5-bit address. `dbg_data` shows the register chosen by `dbg_addr` in the same cycle, with no clock edge needed.
- R2: While `rst_n` is low, every register is forced to zero. Reset is asynchronous and active low.
- R3: A word with bits [31:26]=0 and bits [5:0]=0x20 adds the register named in bits [25:21] to the register named in bits [20:16], modulo 2^32. The sum goes to the register named in bits [15:11].
- R4: A word with bits [31:26]=0x08 adds the register named in bits [25:21] to bits [15:0] sign-extended to 32 bits. The sum goes to the register named in bits [20:16].
- R5: A word with bits [31:26]=0 and bits [5:0]=0x00 shifts the register named in bits [20:16] left by bits [10:6], filling with zeros. The result goes to the register named in bits [15:11]. Bits [25:21] have no effect on this operation.
- R6: For the add in R3, bits [10:6] have no effect on the result.
- R7: Register 0 always reads as zero. A write aimed at register 0 is dropped, and `wb_en` stays low for it.
- R8: Any other value of bits [31:26], or of bits [5:0] when bits [31:26]=0, raises `illegal` for that cycle. Such a word keeps `wb_en` low and leaves every register unchanged.
- R9: While `instr_valid` is low, `wb_en` and `illegal` are low and no register changes.
- R10: Operands are read combinationally, and the write lands on the rising edge. An instruction that names the same register as both source and destination therefore uses the old value. `wb_addr` and `wb_data` give the destination and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| dbg_addr | input | 5 | Debug read register select |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_addr | output | 5 | Destination register of the current instruction |
| wb_data | output | 32 | Value to be written |
| illegal | output | 1 | Current valid word is unsupported |
| dbg_data | output | 32 | Contents of register `dbg_addr` |

## Verification
The hardest case to reach from the ports is an instruction whose source and destination are the same register. Only then does the old-value-on-read rule show, and reaching it needs a known nonzero value already in that register. The stimulus table first loads registers with constant-add instructions from register 0, and so builds the needed state through the normal interface. It then issues a self-referencing add, whose result depends on the old value having been read. Sign extension is exercised with 0x7FFF and 0x8000 constants. A shift by 31 and nonzero shift fields on adds cover the shift-field cases.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

  localparam int unsigned OPW   = 6;
  localparam int unsigned FNW   = 6;
  localparam int unsigned RIDW  = 5;
  localparam int unsigned IMMW  = 16;

  localparam logic [OPW-1:0] OP_REGREG = 6'h00;
  localparam logic [OPW-1:0] OP_ADDIMM = 6'h08;
  localparam logic [FNW-1:0] FN_ADD    = 6'h20;
  localparam logic [FNW-1:0] FN_SHL    = 6'h00;

  typedef enum logic [0:0] {
    ALU_SUM = 1'b0,
    ALU_SHL = 1'b1
  } alu_sel_e;

  typedef struct packed {
    logic            legal;
    alu_sel_e        sel;
    logic            use_imm;
    logic [RIDW-1:0] src_a;
    logic [RIDW-1:0] src_b;
    logic [RIDW-1:0] dest;
    logic [RIDW-1:0] shamt;
    logic [IMMW-1:0] imm;
  } dec_t;

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
  import rfx_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [OPW-1:0] op;
  logic [FNW-1:0] fn;

  assign op = instr[31:26];
  assign fn = instr[5:0];

  always_comb begin
    dec         = '0;
    dec.src_a   = instr[25:21];
    dec.src_b   = instr[20:16];
    dec.shamt   = instr[10:6];
    dec.imm     = instr[15:0];
    dec.sel     = ALU_SUM;
    dec.use_imm = 1'b0;
    dec.dest    = instr[15:11];
    dec.legal   = 1'b0;
    unique case (op)
      OP_REGREG: begin
        unique case (fn)
          FN_ADD: begin
            dec.legal = 1'b1;
            dec.sel   = ALU_SUM;
          end
          FN_SHL: begin
            dec.legal = 1'b1;
            dec.sel   = ALU_SHL;
          end
          default: dec.legal = 1'b0;
        endcase
      end
      OP_ADDIMM: begin
        dec.legal   = 1'b1;
        dec.sel     = ALU_SUM;
        dec.use_imm = 1'b1;
        dec.dest    = instr[20:16];
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/rfx_alu.sv
module rfx_alu
  import rfx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_sel_e        sel,
  input  logic            use_imm,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [IMMW-1:0] imm,
  input  logic [RIDW-1:0] shamt,
  output logic [XLEN-1:0] result
);

  localparam int unsigned EXTW = XLEN - IMMW;

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] addend;

  assign imm_ext = {{EXTW{imm[IMMW-1]}}, imm};
  assign addend  = use_imm ? imm_ext : opb;

  always_comb begin
    unique case (sel)
      ALU_SHL: result = opb << shamt;
      default: result = opa + addend;
    endcase
  end

endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra_addr,
  input  logic [AW-1:0]   rb_addr,
  input  logic [AW-1:0]   dbg_addr,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  output logic [XLEN-1:0] dbg_data
);

  logic [XLEN-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_store
      logic            en;
      logic [XLEN-1:0] q_r;
      logic [XLEN-1:0] q_d;

      assign en = we && (waddr == AW'(g));

      always_comb begin
        q_d = q_r;
        if (en) q_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_d;
      end

      assign bank[g] = q_r;
    end
  end

  assign ra_data  = bank[ra_addr];
  assign rb_data  = bank[rb_addr];
  assign dbg_data = bank[dbg_addr];

endmodule

// File: rtl/rfx_exec_top.sv
module rfx_exec_top
  import rfx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [AW-1:0]   dbg_addr,
  output logic            wb_en,
  output logic [AW-1:0]   wb_addr,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal,
  output logic [XLEN-1:0] dbg_data
);

  dec_t            dec;
  logic [XLEN-1:0] opa;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] result;

  rfx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  rfx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_addr  (dec.src_a[AW-1:0]),
    .rb_addr  (dec.src_b[AW-1:0]),
    .dbg_addr (dbg_addr),
    .we       (wb_en),
    .waddr    (wb_addr),
    .wdata    (wb_data),
    .ra_data  (opa),
    .rb_data  (opb),
    .dbg_data (dbg_data)
  );

  rfx_alu #(.XLEN(XLEN)) u_alu (
    .sel     (dec.sel),
    .use_imm (dec.use_imm),
    .opa     (opa),
    .opb     (opb),
    .imm     (dec.imm),
    .shamt   (dec.shamt),
    .result  (result)
  );

  assign wb_addr = dec.dest[AW-1:0];
  assign wb_data = result;
  assign wb_en   = instr_valid && dec.legal && (wb_addr != '0);
  assign illegal = instr_valid && !dec.legal;

endmodule

// File: rtl/rfx_exec_chk.sv
module rfx_exec_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic [AW-1:0]   dbg_addr,
  input logic            wb_en,
  input logic [AW-1:0]   wb_addr,
  input logic [XLEN-1:0] wb_data,
  input logic            illegal,
  input logic [XLEN-1:0] dbg_data
);

  p_zero_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_data == '0));

  p_no_write_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_addr != '0));

  p_illegal_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!wb_en && !illegal));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> ((dbg_addr != $past(wb_addr)) || (dbg_data == $past(wb_data))));

  p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wb_en) && $stable(dbg_addr)) |-> $stable(dbg_data));

  p_imm_dest_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && instr[31:26] == 6'h08) |-> (wb_addr == instr[20:16]));

endmodule

bind rfx_exec_top rfx_exec_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .dbg_addr    (dbg_addr),
  .wb_en       (wb_en),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .illegal     (illegal),
  .dbg_data    (dbg_data)
);

// File: tb/rfx_exec_top_tb.sv
module rfx_exec_top_tb;

  function automatic logic [31:0] e_addi(int rt, int rs, logic [15:0] imm);
    return {6'h08, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] e_add(int rd, int rs, int rt, int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'h20};
  endfunction
  function automatic logic [31:0] e_shl(int rd, int rt, int sh, int rs);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'h00};
  endfunction

  localparam int NV = 14;
  localparam logic [31:0] V_INS [NV] = '{
    e_addi(1, 0, 16'h0005),
    e_addi(2, 0, 16'hFFFD),
    e_add(3, 1, 2, 0),
    e_addi(4, 0, 16'h7FFF),
    e_shl(5, 4, 16, 1),
    e_add(6, 5, 5, 7),
    e_addi(7, 5, 16'h8000),
    e_add(0, 1, 1, 0),
    32'h8C22_0004,
    32'h0021_1822,
    e_add(1, 1, 1, 0),
    e_shl(8, 2, 31, 0),
    e_shl(9, 1, 0, 3),
    e_addi(10, 9, 16'hFFF6)
  };
  localparam logic V_EN  [NV] = '{1,1,1,1,1,1,1,0,0,0,1,1,1,1};
  localparam logic V_ILL [NV] = '{0,0,0,0,0,0,0,0,1,1,0,0,0,0};
  localparam logic [4:0] V_ADDR [NV] = '{1,2,3,4,5,6,7,0,0,0,1,8,9,10};
  localparam logic [31:0] V_DATA [NV] = '{
    32'd5, 32'hFFFF_FFFD, 32'd2, 32'h0000_7FFF, 32'h7FFF_0000,
    32'hFFFE_0000, 32'h7FFE_8000, 32'd0, 32'd0, 32'd0,
    32'd10, 32'h8000_0000, 32'd10, 32'd0
  };
  localparam string V_REQ [NV] = '{"R4","R4","R3","R4","R5","R6","R4",
                                   "R7","R8","R8","R10","R5","R5","R4"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic [4:0]  dbg_addr;
  logic        wb_en;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;
  logic        illegal;
  logic [31:0] dbg_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rfx_exec_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .dbg_addr    (dbg_addr),
    .wb_en       (wb_en),
    .wb_addr     (wb_addr),
    .wb_data     (wb_data),
    .illegal     (illegal),
    .dbg_data    (dbg_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(string req, int r, logic [31:0] exp);
    @(negedge clk);
    instr_valid = 1'b0;
    dbg_addr    = 5'(r);
    #2;
    chk(req, dbg_data, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    instr_valid = 1'b0;
    instr       = '0;
    dbg_addr    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state, read through R1 debug port
    for (int r = 0; r < 32; r += 7) peek("R2", r, 32'd0);
    peek("R1", 31, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = V_INS[i];
      #5;
      chk(V_REQ[i], {31'd0, wb_en}, {31'd0, V_EN[i]});
      chk(V_REQ[i], {31'd0, illegal}, {31'd0, V_ILL[i]});
      if (V_EN[i]) begin
        chk(V_REQ[i], {27'd0, wb_addr}, {27'd0, V_ADDR[i]});
        chk(V_REQ[i], wb_data, V_DATA[i]);
      end
      if (V_EN[i]) peek(V_REQ[i], int'(V_ADDR[i]), V_DATA[i]);
    end

    // R7 register 0 still zero after attempted write
    peek("R7", 0, 32'd0);
    // R8 illegal words left registers alone
    peek("R8", 3, 32'd2);
    peek("R8", 2, 32'hFFFF_FFFD);
    // R10 self-referencing add used the old value
    peek("R10", 1, 32'd10);
    peek("R1", 7, 32'h7FFE_8000);

    // R9 word held with valid low: no write, no flag
    @(negedge clk);
    instr_valid = 1'b0;
    instr       = e_add(11, 1, 1, 0);
    #5;
    chk("R9", {30'd0, wb_en, illegal}, 32'd0);
    peek("R9", 11, 32'd0);

    // R2 asynchronous reset mid-run clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    dbg_addr = 5'd1;
    #1;
    chk("R2", dbg_data, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    peek("R2", 7, 32'd0);
    peek("R2", 8, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule